// File: doc/BRIEF.md
# Serial Conversion Result Shifter

This block models the digital output stage of a 16-bit sampling converter. A one-cycle convert request starts a conversion of fixed length on the system clock, and busy is high while it runs. When the conversion ends, the parallel sample value is captured into an output shift register. A host then clocks that word out, most significant bit first, on its own serial clock while chip select and read enable are low. The serial clock, chip select and read enable are synchronized into the system clock domain. Shifting follows the detected rising edges of the synchronized serial clock.

There are two read modes. In read-during-conversion mode the host reads the previous result while the next conversion runs. If it starts a read but has not taken all 16 bits when that conversion ends, a one-cycle read-error pulse is raised, and the chain input is ignored. In read-after-conversion mode, serial clock edges are ignored while busy is high. The chain input is shifted into the low end of the register, so a second identical stage wired to it has its word follow this stage's own word on the serial output.

Top module: `serialResultPort`

## Requirements
- R1: One cycle after convStart is sampled high with busy low, busy rises and stays high for exactly CONV_CYCLES system cycles. A convStart that arrives while busy is high has no effect on that length.
- R2: On the clock edge where busy falls, sampleIn is captured. Before any serial clock edge, dataOut shows bit 15 of the captured word.
- R3: While csN and rdN are low, each synchronized rising edge of sclk after the first advances dataOut by one bit. The host therefore sees bits 15 down to 0 of the word on 16 consecutive serial clock periods, and each bit holds across both edges of its period.
- R4: In read-during-conversion mode (modeAfter = 0), a read made while busy is high returns the result of the previous conversion. The sampleIn of the running conversion does not appear.
- R5: In read-during-conversion mode, reading 16 or more bits before the conversion ends produces no readErr pulse.
- R6: In read-during-conversion mode, if 1 to 15 rising edges have been counted when the conversion ends, readErr is high for exactly one cycle, starting on the same edge where busy falls. With no edges counted, no pulse is raised.
- R7: In read-during-conversion mode, chainIn is ignored and zeros follow the 16 result bits on dataOut.
- R8: In read-after-conversion mode (modeAfter = 1), chainIn enters the low end of the register on each shift. With an upstream stage driving chainIn, 32 reads return this stage's word followed by the upstream word.
- R9: In read-after-conversion mode, serial clock edges while busy is high neither shift nor count, and dataOut stays unchanged.
- R10: Serial clock edges have no effect while csN or rdN is high. csN high clears the bit count.
- R11: During reset, busy, readErr and dataOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | One-cycle request to start a conversion |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read enable, active low, asynchronous |
| sclk | input | 1 | Host serial clock, idle low |
| chainIn | input | 1 | Serial data from an upstream stage |
| modeAfter | input | 1 | 0 = read during conversion, 1 = read after conversion |
| sampleIn | input | WORD_W | Parallel value captured at end of conversion |
| busy | output | 1 | High while a conversion runs |
| dataOut | output | 1 | Serial result, MSB first |
| readErr | output | 1 | One-cycle pulse on an incomplete read during conversion |

## Verification
The hardest situation to reach is a read that is still incomplete at the exact edge where the conversion ends. Serial edges only become visible after the synchronizer delay, so the bench lengthens the conversion through the CONV_CYCLES parameter. It paces the serial clock at a fixed number of system cycles per half period, so that a 10-bit read is known to finish well inside the window. It then holds select low across the end of the conversion. The chained case uses a second instance driven by the same serial clock and selects, so the upstream bits enter in lockstep.

// File: rtl/resShiftPkg.sv
package resShiftPkg;

  typedef struct packed {
    logic loadWord;
    logic shiftBit;
    logic countEdge;
    logic clearCnt;
  } strobeT;

endpackage

// File: rtl/resSync.sv
module resSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= {STAGES{RESET_VAL}};
        else       stg <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= {STAGES{RESET_VAL}};
        else       stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/resCtrl.sv
module resCtrl
  import resShiftPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CONV_CYCLES = 40,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             modeAfter,
  input  logic             sclkRise,
  input  logic             csLow,
  input  logic             rdLow,
  input  logic [CNT_W-1:0] bitCnt,
  output logic             busy,
  output logic             readErr,
  output strobeT           strobe
);

  localparam int CONV_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [CONV_W-1:0] convCnt;
  logic endConv;
  logic readGate;
  logic edgeOk;
  logic partialRead;

  assign endConv     = busy && (convCnt == '0);
  assign readGate    = csLow && rdLow && (!modeAfter || !busy);
  assign edgeOk      = sclkRise && readGate && !endConv;
  assign partialRead = (bitCnt != '0) && (bitCnt < FULL_CNT);

  always_comb begin
    strobe.loadWord  = endConv;
    strobe.countEdge = edgeOk;
    strobe.shiftBit  = edgeOk && (bitCnt != '0);
    strobe.clearCnt  = !csLow || endConv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      convCnt <= '0;
    end else if (busy) begin
      if (convCnt == '0) busy <= 1'b0;
      else               convCnt <= convCnt - 1'b1;
    end else if (convStart) begin
      busy    <= 1'b1;
      convCnt <= CONV_LAST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readErr <= 1'b0;
    else       readErr <= endConv && !modeAfter && partialRead;
  end

  // R1: a conversion only begins on a request
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(convStart));

  // R6: the error pulse coincides with the end of conversion
  p_err_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    readErr |-> $fell(busy));

  // R6: the error pulse only appears in read-during-conversion mode
  p_err_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    readErr |-> !$past(modeAfter));

endmodule

// File: rtl/resPath.sv
module resPath
  import resShiftPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [WORD_W-1:0] sampleIn,
  input  logic              chainIn,
  input  logic              modeAfter,
  output logic              dataOut,
  output logic [CNT_W-1:0]  bitCnt
);

  logic [WORD_W-1:0] shiftReg;
  logic shiftIn;

  assign shiftIn = modeAfter ? chainIn : 1'b0;
  assign dataOut = shiftReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.loadWord) shiftReg <= sampleIn;
    else if (strobe.shiftBit) shiftReg <= {shiftReg[WORD_W-2:0], shiftIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    bitCnt <= '0;
    else if (strobe.clearCnt)                     bitCnt <= '0;
    else if (strobe.countEdge && (bitCnt != '1))  bitCnt <= bitCnt + 1'b1;
  end

  // R2: the captured word equals the sample present at end of conversion
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> (shiftReg == $past(sampleIn)));

  // R10: with no load and no shift request the register holds
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadWord && !strobe.shiftBit) |=> $stable(shiftReg));

  // R10: a clear request empties the bit count
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (bitCnt == '0));

endmodule

// File: rtl/serialResultPort.sv
module serialResultPort
  import resShiftPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sclk,
  input  logic              chainIn,
  input  logic              modeAfter,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              busy,
  output logic              dataOut,
  output logic              readErr
);

  localparam int CNT_W = $clog2(WORD_W) + 2;

  logic       sclkSync;
  logic       sclkPrev;
  logic       sclkRise;
  logic [1:0] selSync;
  logic       csLow;
  logic       rdLow;
  logic [CNT_W-1:0] bitCnt;
  strobeT     strobe;

  resSync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclkSync (
    .clk(clk), .rstN(rstN), .d(sclk), .q(sclkSync)
  );

  resSync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_selSync (
    .clk(clk), .rstN(rstN), .d({csN, rdN}), .q(selSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync;
  end

  assign sclkRise = sclkSync && !sclkPrev;
  assign csLow    = !selSync[1];
  assign rdLow    = !selSync[0];

  resCtrl #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .modeAfter(modeAfter),
    .sclkRise(sclkRise), .csLow(csLow), .rdLow(rdLow), .bitCnt(bitCnt),
    .busy(busy), .readErr(readErr), .strobe(strobe)
  );

  resPath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .chainIn(chainIn), .modeAfter(modeAfter), .dataOut(dataOut), .bitCnt(bitCnt)
  );

  // R9: in read-after mode the output does not move while busy stays high
  p_no_read_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeAfter && busy && $past(modeAfter) && $past(busy)) |-> $stable(dataOut));

endmodule

// File: tb/serialResultPort_bench.sv
module serialResultPort_bench;

  localparam int WORD_W = 16;
  localparam int CONV = 400;
  localparam int HALF = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, convStart, csN, rdN, sclk, modeAfter;
  logic [WORD_W-1:0] downSample, upSample;
  logic downBusy, downOut, downErr;
  logic upBusy, upOut, upErr;

  int checks = 0;
  int failures = 0;
  int errPulses = 0;

  serialResultPort #(.WORD_W(WORD_W), .CONV_CYCLES(CONV)) u_serialResultPort (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .sclk(sclk), .chainIn(upOut), .modeAfter(modeAfter), .sampleIn(downSample),
    .busy(downBusy), .dataOut(downOut), .readErr(downErr)
  );

  serialResultPort #(.WORD_W(WORD_W), .CONV_CYCLES(CONV)) u_upstream (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .sclk(sclk), .chainIn(1'b0), .modeAfter(modeAfter), .sampleIn(upSample),
    .busy(upBusy), .dataOut(upOut), .readErr(upErr)
  );

  always @(posedge clk) if (downErr) errPulses++;

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startConv(input logic [15:0] d, input logic [15:0] u);
    @(negedge clk);
    downSample = d;
    upSample = u;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
  endtask

  task automatic waitIdle();
    while (downBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic selectOn();
    csN = 1'b0; rdN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic selectOff();
    csN = 1'b1; rdN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readBits(input int n, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      w = {w[30:0], downOut};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R11", "busy in reset", 32'(downBusy), 0);
    checkEq("R11", "readErr in reset", 32'(downErr), 0);
    checkEq("R11", "dataOut in reset", 32'(downOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testConvTiming();
    int len;
    int base;
    base = errPulses;
    modeAfter = 1'b1;
    startConv(16'hA5C3, 16'h3C5A);
    checkEq("R1", "busy after start", 32'(downBusy), 1);
    len = 1;
    while (downBusy) begin
      convStart = (len == 10);
      @(negedge clk);
      if (downBusy) len++;
    end
    convStart = 1'b0;
    checkEq("R1", "busy length with extra start", 32'(len), 32'(CONV));
    @(negedge clk);
    checkEq("R1", "busy stays low", 32'(downBusy), 0);
    checkEq("R2", "first bit after capture", 32'(downOut), 1);
    checkEq("R5", "no error in read-after mode", 32'(errPulses - base), 0);
  endtask

  task automatic testBusyIgnored();
    logic [31:0] w;
    modeAfter = 1'b1;
    startConv(16'h1234, 16'h8001);
    selectOn();
    readBits(3, w);
    checkEq("R9", "edges while busy ignored", w, 32'h7);
    checkEq("R9", "still busy during read", 32'(downBusy), 1);
    waitIdle();
    checkEq("R2", "new word bit 15", 32'(downOut), 0);
  endtask

  task automatic testChain();
    logic [31:0] w;
    readBits(32, w);
    checkEq("R8", "chained 32 bits", w, 32'h12348001);
    checkEq("R3", "own word first", {16'h0, w[31:16]}, 32'h1234);
    selectOff();
  endtask

  task automatic testDuringFull();
    logic [31:0] w;
    int base;
    modeAfter = 1'b0;
    base = errPulses;
    startConv(16'h5A69, 16'h0F0F);
    waitIdle();
    checkEq("R6", "no read gives no error", 32'(errPulses - base), 0);
    startConv(16'hFFFF, 16'hFFFF);
    selectOn();
    readBits(20, w);
    checkEq("R4", "previous result during conversion", {16'h0, w[19:4]}, 32'h5A69);
    checkEq("R7", "chainIn ignored, zeros follow", {28'h0, w[3:0]}, 0);
    checkEq("R4", "read completed while busy", 32'(downBusy), 1);
    waitIdle();
    checkEq("R5", "full read gives no error", 32'(errPulses - base), 0);
    selectOff();
  endtask

  task automatic testDuringPartial();
    logic [31:0] w;
    int base;
    modeAfter = 1'b0;
    base = errPulses;
    startConv(16'hC00F, 16'h0000);
    selectOn();
    readBits(10, w);
    checkEq("R3", "partial read bits", w, 32'h3FF);
    waitIdle();
    repeat (3) @(negedge clk);
    checkEq("R6", "one-cycle error pulse", 32'(errPulses - base), 1);
    selectOff();
  endtask

  task automatic testIgnoredSelect();
    logic [31:0] w;
    modeAfter = 1'b1;
    csN = 1'b0; rdN = 1'b1;
    repeat (4) @(negedge clk);
    readBits(3, w);
    checkEq("R10", "rdN high ignores edges", w, 32'h7);
    csN = 1'b1; rdN = 1'b0;
    repeat (4) @(negedge clk);
    readBits(3, w);
    checkEq("R10", "csN high ignores edges", w, 32'h7);
    selectOn();
    readBits(16, w);
    checkEq("R10", "word intact after ignored edges", w, 32'hC00F);
    selectOff();
  endtask

  initial begin
    rstN = 1'b0; convStart = 1'b0; csN = 1'b1; rdN = 1'b1; sclk = 1'b0;
    modeAfter = 1'b0; downSample = '0; upSample = '0;
    testReset();
    testConvTiming();
    testBusyIgnored();
    testChain();
    testDuringFull();
    testDuringPartial();
    testIgnoredSelect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule